// File: doc/BRIEF.md
# Chained Instruction Queue Fetcher

The fetcher reads fixed-size instructions of eight 64-bit words from a linked chain of command-buffer segments in memory. It hands them one at a time to a consumer over a valid/ready stream. A segment holds `8n+1` words: `n` instructions back to back, then one link word that gives the 64-byte-aligned address of the next segment. The read pointer counts in 64-byte lines. It moves up one line per delivered instruction. When the last instruction of a segment has been accepted, the pointer is replaced by the link word's contents.

Software seeds the pointer with a start write while the fetcher is idle. It then rings a doorbell that adds a number of 64-bit words to a pending count. A new instruction is fetched only while the queue is enabled and the pending count covers a whole instruction. Each fetch start subtracts eight words. A byte-order select lets the memory image be big-endian. In that case every instruction word and every link word has its bytes reversed before use.

Back-pressure rules: once `ins_valid` rises, it and `ins_data` hold until `ins_ready` is sampled high. The block buffers one instruction and starts no further read until it is taken. On the memory side, `mem_req_valid` and `mem_req_addr` hold until `mem_req_ready`. Only one read is outstanding, so a response may arrive any cycle after acceptance.

Top module: `chain_fetch`

## Requirements
- R1: An instruction is read as eight word requests at byte addresses `{rd_ptr, k, 3'b000}` for k = 0..7 in order, and word k is presented at `ins_data[64k+63:64k]`.
- R2: An instruction fetch starts only when the pending word count is at least 8, and starting it subtracts 8 from `pending_words`; with no pending words no request is made.
- R3: A doorbell pulse adds `bell_words` to `pending_words`; an addition and a fetch-start subtraction in the same cycle both take effect.
- R4: While `cfg_enable` is low, no instruction or link read begins and the pending count only grows; raising it resumes fetching.
- R5: The instructions per segment are `(cfg_seg_words-1)/8`; after that many instructions are accepted, the word at the current pointer line (segment offset 8n) is read regardless of credit, and `rd_ptr` takes its bits 48:6, its low six bits being ignored.
- R6: With `cfg_big_endian` high, the eight bytes of every instruction word and of the link word are reversed (byte 0 swapped with byte 7, and so on) before use.
- R7: `rd_ptr` shows the next 64-byte line to be read, increments by one on each accepted instruction, and a `start_wr` while idle loads it from `start_ptr` and restarts the segment's instruction count.
- R8: `ins_valid` with `ins_data` stays stable until `ins_ready`, and no memory request is issued while an instruction waits.
- R9: Memory requests hold address and valid until `mem_req_ready`, and at most one read is outstanding.
- R10: After reset `ins_valid` and `mem_req_valid` are low, `pending_words` is 0 and `rd_ptr` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_enable | input | 1 | Queue enable; gates new fetch starts |
| cfg_big_endian | input | 1 | Memory image is big-endian; byte-reverse words |
| cfg_seg_words | input | 13 | Segment size in 64-bit words, legal values 8n+1 |
| start_wr | input | 1 | Load the pointer from `start_ptr` (honoured while idle) |
| start_ptr | input | 43 | Start address bits 48:6 |
| rd_ptr | output | 43 | Next line to read, address bits 48:6 |
| bell_valid | input | 1 | Doorbell pulse |
| bell_words | input | 20 | Words added to the pending count |
| pending_words | output | 20 | Pending doorbell word count |
| mem_req_valid | output | 1 | Word read request valid |
| mem_req_ready | input | 1 | Memory accepts the request |
| mem_req_addr | output | 49 | Byte address of the 64-bit word |
| mem_rsp_valid | input | 1 | Read data valid |
| mem_rsp_data | input | 64 | Read data as stored in memory |
| ins_valid | output | 1 | Instruction available |
| ins_ready | input | 1 | Consumer takes the instruction |
| ins_data | output | 512 | Instruction, word k at bits 64k+63:64k |

## Verification
The hardest case to reach from the ports is a doorbell addition landing in the same clock as a credit take, with the segment's last instruction stalled on the output and the link read queued behind it. The stimulus rings eight words on six consecutive cycles while the consumer's ready toggles in a slow pattern. This spreads the credit takes over the doorbell burst and holds instructions at the boundary between two segments. The memory model varies both request acceptance and response latency, so every state of the fetch sequence waits for a different number of cycles.

// File: rtl/chain_fetch_pkg.sv
package chain_fetch_pkg;
  typedef enum logic [2:0] {
    ST_IDLE,
    ST_WREQ,
    ST_WWAIT,
    ST_HOLD,
    ST_LREQ,
    ST_LWAIT
  } fstate_e;
endpackage

// File: rtl/cf_byte_order.sv
module cf_byte_order #(
  parameter int W = 64
) (
  input  logic         be,
  input  logic [W-1:0] din,
  output logic [W-1:0] dout
);
  localparam int NB = W / 8;
  logic [W-1:0] rev;

  for (genvar g = 0; g < NB; g++) begin : g_byte
    assign rev[8*g +: 8] = din[W-8-8*g +: 8];
  end

  assign dout = be ? rev : din;
endmodule

// File: rtl/cf_credit.sv
module cf_credit #(
  parameter int CNT_W = 20,
  parameter int STEP  = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             add_en,
  input  logic [CNT_W-1:0] add_val,
  input  logic             take,
  output logic [CNT_W-1:0] count,
  output logic             enough
);
  logic [CNT_W-1:0] cnt_q, add_term, sub_term;

  assign add_term = add_en ? add_val : '0;
  assign sub_term = take ? CNT_W'(STEP) : '0;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_q + add_term - sub_term;
  end

  assign count  = cnt_q;
  assign enough = cnt_q >= CNT_W'(STEP);
endmodule

// File: rtl/cf_collect.sv
module cf_collect #(
  parameter int WORD_W = 64,
  parameter int WORDS  = 8,
  localparam int IW    = $clog2(WORDS)
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    wr_en,
  input  logic [IW-1:0]           wr_idx,
  input  logic [WORD_W-1:0]       wr_word,
  input  logic                    out_ready,
  output logic                    out_valid,
  output logic [WORDS*WORD_W-1:0] out_data
);
  logic valid_q;

  for (genvar g = 0; g < WORDS; g++) begin : g_slot
    logic [WORD_W-1:0] word_q;
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                              word_q <= '0;
      else if (wr_en && wr_idx == IW'(g))      word_q <= wr_word;
    end
    assign out_data[g*WORD_W +: WORD_W] = word_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                                  valid_q <= 1'b0;
    else if (wr_en && wr_idx == IW'(WORDS - 1))  valid_q <= 1'b1;
    else if (out_ready)                          valid_q <= 1'b0;
  end

  assign out_valid = valid_q;
endmodule

// File: rtl/chain_fetch.sv
module chain_fetch
  import chain_fetch_pkg::*;
#(
  parameter int ADDR_W    = 49,
  parameter int WORD_W    = 64,
  parameter int INS_WORDS = 8,
  parameter int SEG_W     = 13,
  parameter int CNT_W     = 20,
  localparam int LINE_LSB = $clog2(INS_WORDS * WORD_W / 8),
  localparam int PTR_W    = ADDR_W - LINE_LSB,
  localparam int INS_W    = INS_WORDS * WORD_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cfg_enable,
  input  logic              cfg_big_endian,
  input  logic [SEG_W-1:0]  cfg_seg_words,
  input  logic              start_wr,
  input  logic [PTR_W-1:0]  start_ptr,
  output logic [PTR_W-1:0]  rd_ptr,
  input  logic              bell_valid,
  input  logic [CNT_W-1:0]  bell_words,
  output logic [CNT_W-1:0]  pending_words,
  output logic              mem_req_valid,
  input  logic              mem_req_ready,
  output logic [ADDR_W-1:0] mem_req_addr,
  input  logic              mem_rsp_valid,
  input  logic [WORD_W-1:0] mem_rsp_data,
  output logic              ins_valid,
  input  logic              ins_ready,
  output logic [INS_W-1:0]  ins_data
);
  localparam int WIDX_W = $clog2(INS_WORDS);
  localparam int IDX_W  = SEG_W - WIDX_W;
  localparam int PAD_W  = LINE_LSB - WIDX_W;

  fstate_e            state_q;
  logic [PTR_W-1:0]   ptr_q;
  logic [IDX_W-1:0]   ins_idx_q;
  logic [WIDX_W-1:0]  widx_q;
  logic [SEG_W-1:0]   seg_body;
  logic [IDX_W-1:0]   n_ins;
  logic               seg_done, take, enough, wr_en;
  logic [WORD_W-1:0]  rsp_word;
  logic [WIDX_W-1:0]  word_sel;

  // instructions per segment: (size - 1) / words-per-instruction
  assign seg_body = cfg_seg_words - SEG_W'(1);
  assign n_ins    = seg_body[SEG_W-1:WIDX_W];
  assign seg_done = (ins_idx_q == n_ins);
  assign take     = (state_q == ST_IDLE) && !start_wr && cfg_enable && !seg_done && enough;

  cf_credit #(.CNT_W(CNT_W), .STEP(INS_WORDS)) u_credit (
    .clk     (clk),
    .rst_n   (rst_n),
    .add_en  (bell_valid),
    .add_val (bell_words),
    .take    (take),
    .count   (pending_words),
    .enough  (enough)
  );

  cf_byte_order #(.W(WORD_W)) u_order (
    .be   (cfg_big_endian),
    .din  (mem_rsp_data),
    .dout (rsp_word)
  );

  assign wr_en = (state_q == ST_WWAIT) && mem_rsp_valid;

  cf_collect #(.WORD_W(WORD_W), .WORDS(INS_WORDS)) u_collect (
    .clk       (clk),
    .rst_n     (rst_n),
    .wr_en     (wr_en),
    .wr_idx    (widx_q),
    .wr_word   (rsp_word),
    .out_ready (ins_ready),
    .out_valid (ins_valid),
    .out_data  (ins_data)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q   <= ST_IDLE;
      ptr_q     <= '0;
      ins_idx_q <= '0;
      widx_q    <= '0;
    end else begin
      unique case (state_q)
        ST_IDLE: begin
          if (start_wr) begin
            ptr_q     <= start_ptr;
            ins_idx_q <= '0;
          end else if (cfg_enable) begin
            if (seg_done) begin
              state_q <= ST_LREQ;
            end else if (enough) begin
              state_q <= ST_WREQ;
              widx_q  <= '0;
            end
          end
        end
        ST_WREQ:  if (mem_req_ready) state_q <= ST_WWAIT;
        ST_WWAIT: begin
          if (mem_rsp_valid) begin
            if (widx_q == WIDX_W'(INS_WORDS - 1)) begin
              state_q <= ST_HOLD;
            end else begin
              widx_q  <= widx_q + WIDX_W'(1);
              state_q <= ST_WREQ;
            end
          end
        end
        ST_HOLD: begin
          if (ins_valid && ins_ready) begin
            ptr_q     <= ptr_q + PTR_W'(1);
            ins_idx_q <= ins_idx_q + IDX_W'(1);
            state_q   <= ST_IDLE;
          end
        end
        ST_LREQ:  if (mem_req_ready) state_q <= ST_LWAIT;
        ST_LWAIT: begin
          if (mem_rsp_valid) begin
            ptr_q     <= rsp_word[ADDR_W-1:LINE_LSB];
            ins_idx_q <= '0;
            state_q   <= ST_IDLE;
          end
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  assign word_sel      = (state_q == ST_WREQ) ? widx_q : '0;
  assign mem_req_valid = (state_q == ST_WREQ) || (state_q == ST_LREQ);
  assign mem_req_addr  = {ptr_q, word_sel, {PAD_W{1'b0}}};
  assign rd_ptr        = ptr_q;
endmodule

// File: rtl/chain_fetch_chk.sv
module chain_fetch_chk #(
  parameter int ADDR_W   = 49,
  parameter int INS_W    = 512,
  parameter int PTR_W    = 43,
  parameter int LINE_LSB = 6,
  parameter int WIDX_W   = 3
) (
  input logic              clk,
  input logic              rst_n,
  input logic              cfg_enable,
  input logic [PTR_W-1:0]  rd_ptr,
  input logic              mem_req_valid,
  input logic              mem_req_ready,
  input logic [ADDR_W-1:0] mem_req_addr,
  input logic              mem_rsp_valid,
  input logic              ins_valid,
  input logic              ins_ready,
  input logic [INS_W-1:0]  ins_data
);
  localparam int PAD_W = LINE_LSB - WIDX_W;

  p_hold_out_r8: assert property (@(posedge clk) disable iff (!rst_n)
    ins_valid && !ins_ready |=> ins_valid && $stable(ins_data));

  p_no_req_while_held_r8: assert property (@(posedge clk) disable iff (!rst_n)
    ins_valid |-> !mem_req_valid);

  p_req_stable_r9: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req_valid && !mem_req_ready |=> mem_req_valid && $stable(mem_req_addr));

  p_single_out_r9: assert property (@(posedge clk) disable iff (!rst_n)
    mem_rsp_valid |-> !mem_req_valid);

  p_start_enabled_r4: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(mem_req_valid) && mem_req_addr[LINE_LSB-1:PAD_W] == '0 |-> $past(cfg_enable));

  p_ptr_step_r7: assert property (@(posedge clk) disable iff (!rst_n)
    ins_valid && ins_ready |=> rd_ptr == $past(rd_ptr) + PTR_W'(1));
endmodule

bind chain_fetch chain_fetch_chk #(
  .ADDR_W   (ADDR_W),
  .INS_W    (INS_W),
  .PTR_W    (PTR_W),
  .LINE_LSB (LINE_LSB),
  .WIDX_W   ($clog2(INS_WORDS))
) u_chk (
  .clk           (clk),
  .rst_n         (rst_n),
  .cfg_enable    (cfg_enable),
  .rd_ptr        (rd_ptr),
  .mem_req_valid (mem_req_valid),
  .mem_req_ready (mem_req_ready),
  .mem_req_addr  (mem_req_addr),
  .mem_rsp_valid (mem_rsp_valid),
  .ins_valid     (ins_valid),
  .ins_ready     (ins_ready),
  .ins_data      (ins_data)
);

// File: tb/chain_fetch_bench.sv
`timescale 1ns/1ps
module chain_fetch_bench;
  localparam int ADDR_W = 49;
  localparam int PTR_W  = 43;
  localparam int CNT_W  = 20;

  logic              clk = 1'b0;
  logic              rst_n;
  logic              cfg_enable, cfg_big_endian;
  logic [12:0]       cfg_seg_words;
  logic              start_wr;
  logic [PTR_W-1:0]  start_ptr;
  logic [PTR_W-1:0]  rd_ptr;
  logic              bell_valid;
  logic [CNT_W-1:0]  bell_words;
  logic [CNT_W-1:0]  pending_words;
  logic              mem_req_valid, mem_req_ready;
  logic [ADDR_W-1:0] mem_req_addr;
  logic              mem_rsp_valid;
  logic [63:0]       mem_rsp_data;
  logic              ins_valid, ins_ready;
  logic [511:0]      ins_data;

  chain_fetch u_chain_fetch (
    .clk(clk), .rst_n(rst_n), .cfg_enable(cfg_enable), .cfg_big_endian(cfg_big_endian),
    .cfg_seg_words(cfg_seg_words), .start_wr(start_wr), .start_ptr(start_ptr),
    .rd_ptr(rd_ptr), .bell_valid(bell_valid), .bell_words(bell_words),
    .pending_words(pending_words), .mem_req_valid(mem_req_valid),
    .mem_req_ready(mem_req_ready), .mem_req_addr(mem_req_addr),
    .mem_rsp_valid(mem_rsp_valid), .mem_rsp_data(mem_rsp_data),
    .ins_valid(ins_valid), .ins_ready(ins_ready), .ins_data(ins_data)
  );

  always #2 clk = ~clk;

  int cyc = 0;
  always @(posedge clk) cyc <= cyc + 1;

  int n_checks = 0, n_fail = 0;
  int req_count = 0, ins_count = 0;
  bit be_phase = 0, bp = 0;

  // reference memory and expected instruction stream
  logic [63:0]  mem [longint unsigned];
  logic [511:0] exp_q [$];

  bit              acc_pend = 0, have = 0;
  logic [ADDR_W-1:0] acc_addr, rsp_addr;
  int              delay = 0, lat_sel = 0;

  task automatic chk(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
    n_checks++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic logic [63:0] swap8(input logic [63:0] v);
    logic [63:0] r;
    for (int b = 0; b < 8; b++) r[8*b +: 8] = v[56-8*b +: 8];
    return r;
  endfunction

  task automatic put_seg(input longint unsigned base, input int n, input longint unsigned link,
                         input bit be, input int tagv);
    for (int i = 0; i < n; i++) begin
      logic [511:0] ins;
      for (int k = 0; k < 8; k++) begin
        logic [63:0] v;
        v = {16'(tagv), 16'(i), 16'(k), 16'h5A3C};
        ins[64*k +: 64] = v;
        mem[(base + 64*i + 8*k) >> 3] = be ? swap8(v) : v;
      end
      exp_q.push_back(ins);
    end
    mem[(base + 64*n) >> 3] = be ? swap8(link | 64'h2B) : (link | 64'h2B);
  endtask

  // memory and consumer drivers
  initial begin
    mem_rsp_valid = 0; mem_rsp_data = '0; mem_req_ready = 1; ins_ready = 1;
    forever begin
      @(negedge clk);
      mem_rsp_valid = 0;
      if (acc_pend) begin
        have = 1; rsp_addr = acc_addr; delay = lat_sel % 3; lat_sel++; acc_pend = 0;
      end
      if (have) begin
        if (delay == 0) begin
          longint unsigned key;
          key = longint'(rsp_addr) >> 3;
          mem_rsp_valid = 1;
          mem_rsp_data  = mem.exists(key) ? mem[key] : 64'h0;
          have = 0;
        end else delay--;
      end
      mem_req_ready = (cyc % 4) != 2;
      ins_ready     = bp ? ((cyc % 7) >= 3) : 1'b1;
    end
  end

  // monitor: compares the stream with the reference every clock
  initial begin
    forever begin
      @(negedge clk); #1;
      if (rst_n) begin
        if (mem_req_valid && mem_req_ready) begin
          acc_pend = 1; acc_addr = mem_req_addr; req_count++;
        end
        if (ins_valid && exp_q.size() == 0) begin
          n_checks++; n_fail++;
          $display("FAIL R8 unexpected instruction actual=%0h expected=none", ins_data[63:0]);
        end else if (ins_valid && ins_ready) begin
          logic [511:0] e;
          e = exp_q.pop_front();
          ins_count++;
          n_checks++;
          if (ins_data !== e) begin
            n_fail++;
            $display("FAIL %s instruction %0d actual=%0h expected=%0h",
                     be_phase ? "R6" : "R1", ins_count, ins_data, e);
          end
        end
      end
    end
  end

  task automatic wait_quiet();
    int q = 0, guard = 0;
    while (q < 10 && guard < 3000) begin
      @(negedge clk); #1;
      if (!mem_req_valid && !ins_valid && !mem_rsp_valid && !have && !acc_pend) q++;
      else q = 0;
      guard++;
    end
  endtask

  task automatic ring(input int n);
    @(negedge clk); bell_valid = 1; bell_words = CNT_W'(n);
    @(negedge clk); bell_valid = 0;
  endtask

  task automatic finish_run();
    $display("  [TB] %0d tests run, %0d failed", n_checks, n_fail);
    $finish;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_checks++; n_fail++;
    $display("FAIL watchdog expired actual=%0d expected=done", cyc);
    finish_run();
  end

  initial begin
    rst_n = 0; cfg_enable = 0; cfg_big_endian = 0; cfg_seg_words = 13'd25;
    start_wr = 0; start_ptr = '0; bell_valid = 0; bell_words = '0;
    repeat (5) @(negedge clk);
    #1;
    chk(!ins_valid, "R10 ins_valid", 64'(ins_valid), 0);
    chk(!mem_req_valid, "R10 mem_req_valid", 64'(mem_req_valid), 0);
    chk(pending_words == 0, "R10 pending", 64'(pending_words), 0);
    chk(rd_ptr == 0, "R10 rd_ptr", 64'(rd_ptr), 0);
    @(negedge clk); rst_n = 1;

    put_seg(64'h1000, 3, 64'h4000, 0, 1);
    put_seg(64'h4000, 3, 64'h8000, 0, 2);
    put_seg(64'h8000, 3, 64'hC000, 0, 3);
    put_seg(64'hC000, 3, 64'h10000, 0, 4);
    put_seg(64'h20000, 2, 64'h30000, 1, 5);

    @(negedge clk); start_wr = 1; start_ptr = PTR_W'(64'h40);
    @(negedge clk); start_wr = 0; cfg_enable = 1;
    repeat (20) @(negedge clk);
    #1;
    chk(req_count == 0, "R2 no credit no request", 64'(req_count), 0);
    chk(rd_ptr == 43'h40, "R7 start load", 64'(rd_ptr), 64'h40);

    ring(16); wait_quiet();
    chk(ins_count == 2, "R2 two instructions", 64'(ins_count), 2);
    chk(req_count == 16, "R1 word requests", 64'(req_count), 16);
    chk(pending_words == 0, "R2 credit consumed", 64'(pending_words), 0);
    chk(rd_ptr == 43'h42, "R7 pointer step", 64'(rd_ptr), 64'h42);

    ring(8); wait_quiet();
    chk(ins_count == 3, "R5 last of segment", 64'(ins_count), 3);
    chk(req_count == 25, "R5 link read without credit", 64'(req_count), 25);
    chk(rd_ptr == 43'h100, "R5 link followed", 64'(rd_ptr), 64'h100);

    @(negedge clk); cfg_enable = 0;
    ring(24);
    repeat (20) @(negedge clk);
    #1;
    chk(req_count == 25, "R4 disabled no request", 64'(req_count), 25);
    chk(pending_words == 24, "R3 doorbell adds", 64'(pending_words), 24);
    @(negedge clk); cfg_enable = 1;
    wait_quiet();
    chk(ins_count == 6, "R4 resumed", 64'(ins_count), 6);
    chk(rd_ptr == 43'h200, "R5 second link", 64'(rd_ptr), 64'h200);
    chk(pending_words == 0, "R4 credit drained", 64'(pending_words), 0);

    bp = 1;
    for (int i = 0; i < 6; i++) begin
      @(negedge clk); bell_valid = 1; bell_words = 20'd8;
    end
    @(negedge clk); bell_valid = 0;
    wait_quiet();
    chk(ins_count == 12, "R8 all delivered under back-pressure", 64'(ins_count), 12);
    chk(pending_words == 0, "R3 add and take together", 64'(pending_words), 0);
    chk(rd_ptr == 43'h400, "R5 chain across segments", 64'(rd_ptr), 64'h400);

    bp = 0;
    @(negedge clk); cfg_enable = 0;
    wait_quiet();
    @(negedge clk); cfg_big_endian = 1; cfg_seg_words = 13'd17; be_phase = 1;
    start_wr = 1; start_ptr = PTR_W'(64'h800);
    @(negedge clk); start_wr = 0; cfg_enable = 1;
    #1;
    chk(rd_ptr == 43'h800, "R7 restart pointer", 64'(rd_ptr), 64'h800);
    ring(16); wait_quiet();
    chk(ins_count == 14, "R6 big-endian instructions", 64'(ins_count), 14);
    chk(rd_ptr == 43'hC00, "R6 swapped link, low bits ignored", 64'(rd_ptr), 64'hC00);
    chk(exp_q.size() == 0, "R1 stream complete", 64'(exp_q.size()), 0);

    finish_run();
  end
endmodule